// File: doc/BRIEF.md
# Bus Parity Generator and Error Reporter

This block sits beside the bus sequencer of an agent on a 32-bit multiplexed address/data bus that also carries 4 active-low command/byte-enable lines and one parity line. It makes the parity bit whenever the local agent is the one driving the bus lines. That covers the address and write data when the agent is master, and read data when it is target. The parity bit always appears one clock after the lines it covers.

When the agent receives data or an address, the block checks the parity line one clock after the covered lines were sampled. A data mismatch drives the active-low data-error line two clocks after the transfer. After its last low clock the line is driven high for one clock and is then released. A mismatch on an address drives the shared open-drain system-error line low for exactly one clock. That line is never driven high.

Reporting is allowed only when the access has been claimed and the data phase has completed. A global enable silences both error outputs without stopping parity generation. A sticky flag records every mismatch seen since reset.

Top module: `bpu_top`

## Requirements
- R1: `par_o` equals the XOR of the 32 `ad_i` bits and the 4 `cbe_n_i` bits sampled one clock earlier, so that the lines plus parity hold an even number of ones.
- R2: `par_oe_o` is high in the clock after a cycle in which `own_mst_i` is high together with either `addr_ph_i`, or `wr_i` with `irdy_i`.
- R3: `par_oe_o` is high in the clock after a cycle with `own_tgt_i`, `wr_i` low and `trdy_i`. In all other cases it is low, for example a target during a write or a master during a read.
- R4: In a cycle that does not drive parity, `par_o` holds its previous value.
- R5: A completed received data phase is a cycle with `irdy_i`, `trdy_i`, `devsel_i`, no `addr_ph_i`, and either `own_tgt_i` with `wr_i` or `own_mst_i` without `wr_i`. If `par_i` in the next cycle mismatches the parity of that phase, `perr_n_o` is low with `perr_oe_o` high in the clock two cycles after the phase.
- R6: Erroneous phases in consecutive cycles keep `perr_n_o` low for the same number of consecutive clocks.
- R7: After its last low clock, `perr_n_o` is driven high with `perr_oe_o` high for exactly one clock, and `perr_oe_o` then falls.
- R8: No data error is reported for a phase that lacks `devsel_i`, or that lacks `irdy_i` together with `trdy_i`, or in which the agent is not the receiver.
- R9: If an address phase is seen with `own_mst_i` low and `par_i` mismatches in the next cycle, `serr_oe_o` (the drive-low enable) is high for exactly one clock, two cycles after the address phase. An address the agent drives itself is not checked.
- R10: With `report_en_i` low in the clock that a mismatch is detected, neither `perr_oe_o` nor `serr_oe_o` rises. Parity generation is unaffected.
- R11: `err_sticky_o` goes high on any detected data or address mismatch, whether or not reporting is enabled, and only reset clears it.
- R12: During reset, `par_o`, `par_oe_o`, `perr_oe_o`, `serr_oe_o` and `err_sticky_o` are low and `perr_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Sampled address/data lines |
| cbe_n_i | input | 4 | Sampled command/byte-enable lines |
| par_i | input | 1 | Sampled parity line |
| addr_ph_i | input | 1 | Current cycle is an address phase |
| irdy_i | input | 1 | Initiator ready (active high) |
| trdy_i | input | 1 | Target ready (active high) |
| devsel_i | input | 1 | Some device has claimed the access |
| wr_i | input | 1 | Current transaction is a write |
| own_mst_i | input | 1 | Local agent is master of the transaction |
| own_tgt_i | input | 1 | Local agent has claimed it as target |
| report_en_i | input | 1 | Enables error outputs |
| par_o | output | 1 | Generated parity value |
| par_oe_o | output | 1 | Parity line output enable |
| perr_n_o | output | 1 | Data-error line value (active low) |
| perr_oe_o | output | 1 | Data-error line output enable |
| serr_oe_o | output | 1 | System-error pull-down enable |
| err_sticky_o | output | 1 | Any mismatch seen since reset |

## Verification
The bench aims at the exact two-clock latency of error reports. A pipeline that is one stage short or long shows up as a low at the wrong clock. It drives back-to-back bad phases so that a release sequencer which goes high between them is caught. It also drives a lone bad phase to check for exactly one high-driven clock before release. It sends bad parity on phases without a claim or without both ready strobes, and on addresses the agent drives itself, where a loose gate would report falsely. Reporting is switched off during mismatches so that a design which gates the sticky flag or parity generation with the enable will diverge from the model.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    PE_IDLE = 2'd0,
    PE_LOW  = 2'd1,
    PE_HIGH = 2'd2
  } perr_st_t;
endpackage

// File: rtl/bpu_par_gen.sv
module bpu_par_gen #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             addr_ph_i,
  input  logic             irdy_i,
  input  logic             trdy_i,
  input  logic             wr_i,
  input  logic             own_mst_i,
  input  logic             own_tgt_i,
  output logic             par_o,
  output logic             par_oe_o
);
  localparam int TOT_W = AD_W + CBE_W;

  logic [TOT_W-1:0] lines;
  logic gen_now, par_d, par_q, oe_q;

  assign lines   = {ad_i, cbe_n_i};
  assign gen_now = (own_mst_i & (addr_ph_i | (wr_i & irdy_i)))
                 | (own_tgt_i & ~wr_i & trdy_i);

  always_comb begin
    par_d = par_q;
    if (gen_now) par_d = ^lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= gen_now;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

  // R2 / R3: parity drive only follows a cycle where this agent owned the lines
  p_oe_needs_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> $past(own_mst_i | own_tgt_i));
  // R4: value holds across cycles that do not drive
  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gen_now) |-> $stable(par_o));
endmodule

// File: rtl/bpu_par_check.sv
module bpu_par_check #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             par_i,
  input  logic             addr_ph_i,
  input  logic             irdy_i,
  input  logic             trdy_i,
  input  logic             devsel_i,
  input  logic             wr_i,
  input  logic             own_mst_i,
  input  logic             own_tgt_i,
  output logic             data_err_o,
  output logic             addr_err_o
);
  localparam int TOT_W = AD_W + CBE_W;

  logic [TOT_W-1:0] lines;
  logic calc_par, rx_data, rx_addr;
  logic dv_q, av_q, exp_q, exp_d;

  assign lines    = {ad_i, cbe_n_i};
  assign calc_par = ^lines;
  assign rx_data  = irdy_i & trdy_i & devsel_i & ~addr_ph_i
                  & ((own_tgt_i & wr_i) | (own_mst_i & ~wr_i));
  assign rx_addr  = addr_ph_i & ~own_mst_i;

  always_comb begin
    exp_d = exp_q;
    if (rx_data | rx_addr) exp_d = calc_par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      av_q  <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      dv_q  <= rx_data;
      av_q  <= rx_addr;
      exp_q <= exp_d;
    end
  end

  assign data_err_o = dv_q & (exp_q != par_i);
  assign addr_err_o = av_q & (exp_q != par_i);

  // R8: a data error is only raised for a claimed, completed phase
  p_claim_before_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_err_o |-> $past(devsel_i & irdy_i & trdy_i));
  // R9: own address phases are never checked
  p_no_self_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> !$past(own_mst_i));
endmodule

// File: rtl/bpu_err_drive.sv
module bpu_err_drive
  import bpu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic data_err_i,
  input  logic addr_err_i,
  input  logic report_en_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic serr_oe_o,
  output logic err_sticky_o
);
  perr_st_t st_q, st_d;
  logic serr_q, serr_d, sticky_q, sticky_d;

  always_comb begin
    st_d = PE_IDLE;
    if (data_err_i & report_en_i) st_d = PE_LOW;
    else if (st_q == PE_LOW)      st_d = PE_HIGH;
    serr_d   = addr_err_i & report_en_i & ~serr_q;
    sticky_d = sticky_q | data_err_i | addr_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PE_IDLE;
      serr_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      serr_q   <= serr_d;
      sticky_q <= sticky_d;
    end
  end

  assign perr_n_o     = (st_q != PE_LOW);
  assign perr_oe_o    = (st_q != PE_IDLE);
  assign serr_oe_o    = serr_q;
  assign err_sticky_o = sticky_q;

  // R7: release only after a high-driven clock
  p_high_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_oe_o) |-> $past(perr_n_o));
  // R9: system error lasts a single clock
  p_serr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe_o |=> !serr_oe_o);
  // R10: error drive starts only while reporting is enabled
  p_perr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_oe_o) |-> $past(report_en_i));
  p_serr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe_o |-> $past(report_en_i));
  // R11: sticky flag never clears outside reset
  p_sticky_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_sticky_o));
endmodule

// File: rtl/bpu_top.sv
module bpu_top #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             par_i,
  input  logic             addr_ph_i,
  input  logic             irdy_i,
  input  logic             trdy_i,
  input  logic             devsel_i,
  input  logic             wr_i,
  input  logic             own_mst_i,
  input  logic             own_tgt_i,
  input  logic             report_en_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  output logic             serr_oe_o,
  output logic             err_sticky_o
);
  logic data_err, addr_err;

  bpu_par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
    .addr_ph_i(addr_ph_i), .irdy_i(irdy_i), .trdy_i(trdy_i), .wr_i(wr_i),
    .own_mst_i(own_mst_i), .own_tgt_i(own_tgt_i),
    .par_o(par_o), .par_oe_o(par_oe_o)
  );

  bpu_par_check #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i), .par_i(par_i),
    .addr_ph_i(addr_ph_i), .irdy_i(irdy_i), .trdy_i(trdy_i),
    .devsel_i(devsel_i), .wr_i(wr_i), .own_mst_i(own_mst_i),
    .own_tgt_i(own_tgt_i), .data_err_o(data_err), .addr_err_o(addr_err)
  );

  bpu_err_drive u_drv (
    .clk(clk), .rst_n(rst_n), .data_err_i(data_err), .addr_err_i(addr_err),
    .report_en_i(report_en_i), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
    .serr_oe_o(serr_oe_o), .err_sticky_o(err_sticky_o)
  );

  // R5 / R8: every low clock traces back to a claimed, completed phase two clocks earlier
  p_low_two_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(devsel_i & irdy_i & trdy_i, 2));
  // R5: the line is only low while it is driven
  p_low_is_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe_o);
endmodule

// File: tb/tb_bpu_top.sv
`timescale 1ns/100ps
module tb_bpu_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic par_in, aph, ir, tr, ds, wr, om, ot, rep;
  logic par_o, par_oe, perr_n, perr_oe, serr_oe, sticky;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R12 reset";
  logic prev_par = 1'b0;

  always #2.5 clk = ~clk;

  bpu_top dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe), .par_i(par_in),
    .addr_ph_i(aph), .irdy_i(ir), .trdy_i(tr), .devsel_i(ds), .wr_i(wr),
    .own_mst_i(om), .own_tgt_i(ot), .report_en_i(rep),
    .par_o(par_o), .par_oe_o(par_oe), .perr_n_o(perr_n), .perr_oe_o(perr_oe),
    .serr_oe_o(serr_oe), .err_sticky_o(sticky)
  );

  // behavioural reference model
  logic m_par, m_paroe, m_lo, m_hi, m_serr, m_sticky;
  logic m_dv, m_av, m_exp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_par = 0; m_paroe = 0; m_lo = 0; m_hi = 0; m_serr = 0; m_sticky = 0;
      m_dv = 0; m_av = 0; m_exp = 0;
    end else begin
      bit gen, derr, aerr, rxd, rxa, p;
      p    = ($countones({ad, cbe}) % 2) == 1;
      gen  = (om && (aph || (wr && ir))) || (ot && !wr && tr);
      derr = m_dv && (m_exp != par_in);
      aerr = m_av && (m_exp != par_in);
      if (gen) m_par = p;
      m_paroe  = gen;
      m_sticky = m_sticky || derr || aerr;
      m_hi     = m_lo && !(derr && rep);
      m_lo     = derr && rep;
      m_serr   = aerr && rep && !m_serr;
      rxd = ir && tr && ds && !aph && ((ot && wr) || (om && !wr));
      rxa = aph && !om;
      if (rxd || rxa) m_exp = p;
      m_dv = rxd; m_av = rxa;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%b expected=%b at %0t", req, cur_tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 parity value", par_o, m_par);
    chk("R2 parity enable", par_oe, m_paroe);
    chk("R5 perr level", perr_n, !m_lo);
    chk("R7 perr enable", perr_oe, m_lo || m_hi);
    chk("R9 serr enable", serr_oe, m_serr);
    chk("R11 sticky", sticky, m_sticky);
  endtask

  task automatic cyc(input string tag, input bit a, input bit m, input bit t,
                     input bit w, input bit i, input bit r, input bit d,
                     input bit bad, input bit en);
    @(negedge clk);
    compare_all();
    cur_tag = tag;
    aph = a; om = m; ot = t; wr = w; ir = i; tr = r; ds = d; rep = en;
    par_in = prev_par ^ bad;
    ad  = $urandom;
    cbe = 4'($urandom);
    prev_par = ^{ad, cbe};
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc("idle R4", 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ad = '0; cbe = '0; par_in = 0; aph = 0; ir = 0; tr = 0;
    ds = 0; wr = 0; om = 0; ot = 0; rep = 1;
    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12 par", par_o, 1'b0);
    chk("R12 par_oe", par_oe, 1'b0);
    chk("R12 perr_n", perr_n, 1'b1);
    chk("R12 perr_oe", perr_oe, 1'b0);
    chk("R12 serr_oe", serr_oe, 1'b0);
    chk("R12 sticky", sticky, 1'b0);
    @(posedge clk); #1 rst_n = 1;
    idle(2);
    // R2: master address then write burst
    cyc("R2 addr", 1, 1, 0, 1, 0, 0, 0, 0, 1);
    cyc("R2 wr", 0, 1, 0, 1, 1, 0, 1, 0, 1);
    cyc("R2 wr", 0, 1, 0, 1, 1, 1, 1, 0, 1);
    cyc("R2 wr", 0, 1, 0, 1, 1, 1, 1, 0, 1);
    idle(3);
    // R3: target read data drive
    cyc("R3 addr", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R3 rd", 0, 0, 1, 0, 1, 0, 1, 0, 1);
    cyc("R3 rd", 0, 0, 1, 0, 1, 1, 1, 0, 1);
    idle(3);
    // R5 / R7: target write with one bad phase
    cyc("R5 wr", 0, 0, 1, 1, 1, 1, 1, 0, 1);
    cyc("R5 bad", 0, 0, 1, 1, 0, 0, 1, 1, 1);
    idle(4);
    // R6: consecutive bad phases
    cyc("R6 wr", 0, 0, 1, 1, 1, 1, 1, 0, 1);
    cyc("R6 wr", 0, 0, 1, 1, 1, 1, 1, 1, 1);
    cyc("R6 wr", 0, 0, 1, 1, 1, 1, 1, 1, 1);
    cyc("R6 end", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    idle(4);
    // R8: bad parity without claim, without completion, or not receiver
    cyc("R8 nodev", 0, 0, 1, 1, 1, 1, 0, 0, 1);
    cyc("R8 nordy", 0, 0, 1, 1, 1, 0, 1, 1, 1);
    cyc("R8 tgtrd", 0, 0, 1, 0, 1, 1, 1, 1, 1);
    cyc("R8 mstwr", 0, 1, 0, 1, 1, 1, 1, 1, 1);
    cyc("R8 end", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    idle(4);
    // R5: master read receive bad
    cyc("R5 mrd", 0, 1, 0, 0, 1, 1, 1, 0, 1);
    cyc("R5 mrd bad", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    idle(4);
    // R9: address errors, foreign and own
    cyc("R9 addr", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R9 bad", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    idle(3);
    cyc("R9 own addr", 1, 1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R9 own bad", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    idle(3);
    // R10 / R11: reporting disabled, mismatches still sticky, parity still made
    rst_n = 0; @(negedge clk); rst_n = 1;
    cyc("R10 wr", 0, 0, 1, 1, 1, 1, 1, 0, 0);
    cyc("R10 bad", 1, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R10 abad", 0, 1, 0, 1, 1, 0, 0, 1, 0);
    cyc("R10 gen", 0, 1, 0, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R10 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      bit rm, rt;
      rm = 1'($urandom); rt = !rm && 1'($urandom);
      cyc("mix R6 R8", ($urandom % 6) == 0, rm, rt, 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) != 0);
    end
    idle(4);
    @(negedge clk); compare_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule